// File: doc/BRIEF.md
# Five-Phase Instruction Control Sequencer

This block is the control unit of a multi-cycle core that spends five clock cycles on every instruction. It counts through the phases fetch, decode, execute, memory and writeback, then starts again at fetch. In each phase it drives one control word to the datapath. That word holds the program-counter increment, the instruction-register load, the operand, result, store-data and writeback staging enables, an ALU operation code, the second-operand select, the memory address source, the read-data routing, the memory strobes and the register-file write. The datapath is a separate block. This block only sees the 4-bit opcode held in the instruction register, which is valid from decode to writeback.

Every opcode gets the same five-phase schedule. An instruction class only turns off the memory or register-write actions it does not need. Moves run through the ALU in a pass-through mode. The halt opcode sets a latch that parks the sequencer at fetch with every strobe low, until a synchronous active-low reset clears it.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is fetch (`phase`=0) with `halted`=0. A reset in the middle of an instruction abandons that instruction.
- R2: `phase` takes the codes fetch=0, decode=1, execute=2, memory=3, writeback=4. It advances by one each cycle, and writeback is followed by fetch.
- R3: In fetch, when not halted, `pc_inc`, `ir_en` and `mem_rd` are 1 and `addr_sel`=0 (PC). `rdata_sel`=0 routes read data to the instruction register. No other strobe is high, and the opcode input has no effect.
- R4: `opa_en` and `opb_en` are 1 in decode and 0 in every other phase.
- R5: In execute, `alu_op` is 0 (add) for 0100, 0101, 0010 and 0011. It is 1 (subtract) for 0110 and 0111, 2 (and) for 1000 and 1001, and 3 (or) for 1010 and 1011. It is 4 (pass operand A) for 0000 and 5 (pass operand B) for 0001. `res_en` is 1 in execute for opcodes 0000 to 1011. `alu_op` is 0 in every other phase.
- R6: In execute, `opb_imm` is 1 (immediate as second operand) exactly for 0001, 0101, 0111, 1001, 1011, 0010 and 0011. It is 0 outside execute.
- R7: In memory, LOAD (0010) drives `addr_sel`=1 (ALU result), `mem_rd`=1, `rdata_sel`=1 and `wb_en`=1.
- R8: STORE (0011) drives `stdata_en`=1 in execute. In memory it drives `addr_sel`=1 and `mem_wr`=1, with `wb_en`=0 and `mem_rd`=0.
- R9: In memory, moves and ALU opcodes (0000, 0001, 0100 to 1011) drive `wb_en`=1 with both memory strobes low and `addr_sel`=0.
- R10: `reg_wr` is 1 only in writeback, and only for 0000, 0001, 0010 and 0100 to 1011. It is never 1 for STORE, HLT or 1101 to 1111.
- R11: HLT (1100) seen in decode sets `halted` from the next cycle. Execute, memory and writeback then pass with all strobes low. The sequencer then stays at fetch with all strobes low, whatever the opcode, until reset.
- R12: Opcodes 1101, 1110 and 1111 act as no-ops: all strobes are low in execute, memory and writeback, and the schedule continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| phase | output | 3 | Current phase code |
| halted | output | 1 | Halt latch |
| pc_inc | output | 1 | Program counter increment |
| ir_en | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Address source: 0 PC, 1 ALU result |
| rdata_sel | output | 1 | Read data to: 0 instruction register, 1 writeback path |
| opa_en | output | 1 | Operand A register load |
| opb_en | output | 1 | Operand B register load |
| opb_imm | output | 1 | ALU second operand: 1 immediate, 0 register |
| alu_op | output | 3 | ALU operation code |
| res_en | output | 1 | ALU result register load |
| stdata_en | output | 1 | Store-data register load |
| wb_en | output | 1 | Writeback register load |
| reg_wr | output | 1 | Register file write |

## Verification
The hardest state to reach from the ports is the parked halt. The opcode only matters in decode, so the bench first walks a full HLT instruction. It then drives a changing stream of opcodes into the parked fetch phase and checks that no strobe moves and that the phase never leaves fetch. After that, only a reset may restart the schedule. A reset asserted in the middle of an instruction is also applied, to show that it abandons the instruction and returns to fetch.

// File: rtl/seq_pkg.sv
// Package: shared phase, ALU and class encodings plus the control word.
// Assumes a 4-bit opcode and a fixed five-phase schedule.
package seq_pkg;
    localparam int OPC_W   = 4;
    localparam int PH_W    = 3;
    localparam int ALUOP_W = 3;
    localparam int PHASES  = 5;

    typedef enum logic [PH_W-1:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4
    } phase_e;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_PASSA = 3'd4,
        ALU_PASSB = 3'd5
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_MOVE, CL_LOAD, CL_STORE, CL_ARITH, CL_HALT, CL_NONE
    } cls_e;

    localparam logic [OPC_W-1:0] OP_MOVR = 4'h0;
    localparam logic [OPC_W-1:0] OP_MOVI = 4'h1;
    localparam logic [OPC_W-1:0] OP_LD   = 4'h2;
    localparam logic [OPC_W-1:0] OP_ST   = 4'h3;
    localparam logic [OPC_W-1:0] OP_ADD  = 4'h4;
    localparam logic [OPC_W-1:0] OP_ADDI = 4'h5;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'h6;
    localparam logic [OPC_W-1:0] OP_SUBI = 4'h7;
    localparam logic [OPC_W-1:0] OP_AND  = 4'h8;
    localparam logic [OPC_W-1:0] OP_ANDI = 4'h9;
    localparam logic [OPC_W-1:0] OP_OR   = 4'hA;
    localparam logic [OPC_W-1:0] OP_ORI  = 4'hB;
    localparam logic [OPC_W-1:0] OP_HLT  = 4'hC;

    typedef struct packed {
        logic          pc_inc;
        logic          ir_en;
        logic          mem_rd;
        logic          mem_wr;
        logic          addr_sel;
        logic          rdata_sel;
        logic          opa_en;
        logic          opb_en;
        logic          opb_imm;
        alu_op_e       alu_op;
        logic          res_en;
        logic          stdata_en;
        logic          wb_en;
        logic          reg_wr;
    } ctrl_word_t;
endpackage

// File: rtl/seq_opdecode.sv
// Opcode classifier: maps an opcode to its class, ALU operation,
// immediate use and register-write need. Purely combinational.
// Assumes opcodes above HLT are unused and treated as no-ops.
module seq_opdecode
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output cls_e             cls,
    output alu_op_e          op,
    output logic             use_imm,
    output logic             writes_reg
);
    // Class and ALU operation per opcode.
    always_comb begin
        cls     = CL_NONE;
        op      = ALU_ADD;
        use_imm = 1'b0;
        unique case (opc)
            OP_MOVR: begin cls = CL_MOVE;  op = ALU_PASSA; end
            OP_MOVI: begin cls = CL_MOVE;  op = ALU_PASSB; use_imm = 1'b1; end
            OP_LD:   begin cls = CL_LOAD;  op = ALU_ADD;   use_imm = 1'b1; end
            OP_ST:   begin cls = CL_STORE; op = ALU_ADD;   use_imm = 1'b1; end
            OP_ADD:  begin cls = CL_ARITH; op = ALU_ADD;   end
            OP_ADDI: begin cls = CL_ARITH; op = ALU_ADD;   use_imm = 1'b1; end
            OP_SUB:  begin cls = CL_ARITH; op = ALU_SUB;   end
            OP_SUBI: begin cls = CL_ARITH; op = ALU_SUB;   use_imm = 1'b1; end
            OP_AND:  begin cls = CL_ARITH; op = ALU_AND;   end
            OP_ANDI: begin cls = CL_ARITH; op = ALU_AND;   use_imm = 1'b1; end
            OP_OR:   begin cls = CL_ARITH; op = ALU_OR;    end
            OP_ORI:  begin cls = CL_ARITH; op = ALU_OR;    use_imm = 1'b1; end
            OP_HLT:  begin cls = CL_HALT;  end
            default: begin cls = CL_NONE;  end
        endcase
    end

    // Register file is written by moves, loads and ALU operations.
    always_comb begin
        writes_reg = (cls == CL_MOVE) || (cls == CL_LOAD) || (cls == CL_ARITH);
    end
endmodule

// File: rtl/seq_phase_ctr.sv
// Phase counter and halt latch. Counts fetch..writeback and wraps;
// once halted it parks at fetch. Synchronous active-low reset.
// Assumes halt_req is only raised during decode.
module seq_phase_ctr
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_req,
    output phase_e phase,
    output logic   halted
);
    phase_e phase_nx;

    // Next phase: step through the schedule, park at fetch when halted.
    always_comb begin
        unique case (phase)
            PH_FETCH:  phase_nx = halted ? PH_FETCH : PH_DECODE;
            PH_DECODE: phase_nx = PH_EXEC;
            PH_EXEC:   phase_nx = PH_MEM;
            PH_MEM:    phase_nx = PH_WB;
            PH_WB:     phase_nx = PH_FETCH;
            default:   phase_nx = PH_FETCH;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nx;
    end

    // Halt latch: set by a halt request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        halted <= 1'b0;
        else if (halt_req) halted <= 1'b1;
    end
endmodule

// File: rtl/seq_ctrl_gen.sv
// Control word generator: combines phase, halt state and opcode class
// into the per-phase strobes. Every strobe defaults low.
// Assumes the class inputs are valid from decode through writeback.
module seq_ctrl_gen
    import seq_pkg::*;
(
    input  phase_e     phase,
    input  logic       halted,
    input  cls_e       cls,
    input  alu_op_e    op,
    input  logic       use_imm,
    input  logic       writes_reg,
    output ctrl_word_t cw
);
    logic active;

    // Instructions that drive the datapath after decode.
    always_comb begin
        active = (cls != CL_HALT) && (cls != CL_NONE);
    end

    // Per-phase control word.
    always_comb begin
        cw = '0;
        if (!halted) begin
            unique case (phase)
                PH_FETCH: begin
                    cw.pc_inc = 1'b1;
                    cw.ir_en  = 1'b1;
                    cw.mem_rd = 1'b1;
                end
                PH_DECODE: begin
                    cw.opa_en = 1'b1;
                    cw.opb_en = 1'b1;
                end
                PH_EXEC: begin
                    if (active) begin
                        cw.alu_op    = op;
                        cw.opb_imm   = use_imm;
                        cw.res_en    = 1'b1;
                        cw.stdata_en = (cls == CL_STORE);
                    end
                end
                PH_MEM: begin
                    unique case (cls)
                        CL_LOAD: begin
                            cw.addr_sel  = 1'b1;
                            cw.mem_rd    = 1'b1;
                            cw.rdata_sel = 1'b1;
                            cw.wb_en     = 1'b1;
                        end
                        CL_STORE: begin
                            cw.addr_sel = 1'b1;
                            cw.mem_wr   = 1'b1;
                        end
                        CL_MOVE, CL_ARITH: cw.wb_en = 1'b1;
                        default: ;
                    endcase
                end
                PH_WB: cw.reg_wr = writes_reg;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mc_sequencer.sv
// Top of the five-phase control sequencer. Decodes the opcode, runs the
// phase counter with its halt latch and drives the control word ports.
// Assumes opcode holds the instruction register field from decode on.
module mc_sequencer
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    output logic [PH_W-1:0]      phase,
    output logic                 halted,
    output logic                 pc_inc,
    output logic                 ir_en,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 addr_sel,
    output logic                 rdata_sel,
    output logic                 opa_en,
    output logic                 opb_en,
    output logic                 opb_imm,
    output logic [ALUOP_W-1:0]   alu_op,
    output logic                 res_en,
    output logic                 stdata_en,
    output logic                 wb_en,
    output logic                 reg_wr
);
    cls_e       cls;
    alu_op_e    op;
    logic       use_imm;
    logic       writes_reg;
    phase_e     ph;
    logic       halt_q;
    logic       halt_req;
    ctrl_word_t cw;

    seq_opdecode u_dec (
        .opc        (opcode),
        .cls        (cls),
        .op         (op),
        .use_imm    (use_imm),
        .writes_reg (writes_reg)
    );

    // Halt is taken when HLT sits in the instruction register at decode.
    always_comb begin
        halt_req = (ph == PH_DECODE) && (cls == CL_HALT);
    end

    seq_phase_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .phase    (ph),
        .halted   (halt_q)
    );

    seq_ctrl_gen u_gen (
        .phase      (ph),
        .halted     (halt_q),
        .cls        (cls),
        .op         (op),
        .use_imm    (use_imm),
        .writes_reg (writes_reg),
        .cw         (cw)
    );

    // Unpack the control word onto the ports.
    always_comb begin
        phase     = ph;
        halted    = halt_q;
        pc_inc    = cw.pc_inc;
        ir_en     = cw.ir_en;
        mem_rd    = cw.mem_rd;
        mem_wr    = cw.mem_wr;
        addr_sel  = cw.addr_sel;
        rdata_sel = cw.rdata_sel;
        opa_en    = cw.opa_en;
        opb_en    = cw.opb_en;
        opb_imm   = cw.opb_imm;
        alu_op    = cw.alu_op;
        res_en    = cw.res_en;
        stdata_en = cw.stdata_en;
        wb_en     = cw.wb_en;
        reg_wr    = cw.reg_wr;
    end
endmodule

// File: rtl/seq_checker.sv
// Checker for mc_sequencer: temporal properties on its ports.
// Attached with bind below; assumes a synchronous active-low reset.
module seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic       halted,
    input logic       pc_inc,
    input logic       ir_en,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       addr_sel,
    input logic       opa_en,
    input logic       opb_en,
    input logic [2:0] alu_op,
    input logic       wb_en,
    input logic       reg_wr
);
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && !halted) |=> (phase == 3'd1));
    assert_decode_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase == 3'd2));
    assert_wb_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |=> (phase == 3'd0));
    assert_operand_only_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_en || opb_en) |-> (phase == 3'd1));
    assert_alu_op_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd2) |-> (alu_op == 3'd0));
    assert_store_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (phase == 3'd3 && addr_sel && !mem_rd && !wb_en));
    assert_regwr_only_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (phase == 3'd4));
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && phase == 3'd0) |=> (phase == 3'd0 && !pc_inc && !ir_en && !mem_rd));
    assert_mem_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
endmodule

bind mc_sequencer seq_checker i_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .halted   (halted),
    .pc_inc   (pc_inc),
    .ir_en    (ir_en),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .addr_sel (addr_sel),
    .opa_en   (opa_en),
    .opb_en   (opb_en),
    .alu_op   (alu_op),
    .wb_en    (wb_en),
    .reg_wr   (reg_wr)
);

// File: tb/test_mc_sequencer.sv
// Directed bench for mc_sequencer: one task per scenario.
module test_mc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic [2:0] phase;
    logic       halted, pc_inc, ir_en, mem_rd, mem_wr, addr_sel, rdata_sel;
    logic       opa_en, opb_en, opb_imm, res_en, stdata_en, wb_en, reg_wr;
    logic [2:0] alu_op;
    logic [15:0] word;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mc_sequencer i_mc_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .phase(phase), .halted(halted),
        .pc_inc(pc_inc), .ir_en(ir_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_sel(addr_sel), .rdata_sel(rdata_sel), .opa_en(opa_en), .opb_en(opb_en),
        .opb_imm(opb_imm), .alu_op(alu_op), .res_en(res_en), .stdata_en(stdata_en),
        .wb_en(wb_en), .reg_wr(reg_wr)
    );

    assign word = {pc_inc, ir_en, mem_rd, mem_wr, addr_sel, rdata_sel, opa_en, opb_en,
                   opb_imm, alu_op, res_en, stdata_en, wb_en, reg_wr};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected control word from the requirements.
    function automatic logic [15:0] exp_word(int ph, logic [3:0] o);
        logic [15:0] w = '0;
        logic known = (o <= 4'hB);
        case (ph)
            0: begin w[15] = 1; w[14] = 1; w[13] = 1; end
            1: begin w[9] = 1; w[8] = 1; end
            2: if (known) begin
                w[3] = 1;
                w[2] = (o == 4'h3);
                w[7] = (o == 4'h1 || o == 4'h5 || o == 4'h7 || o == 4'h9 ||
                        o == 4'hB || o == 4'h2 || o == 4'h3);
                case (o)
                    4'h0: w[6:4] = 3'd4;
                    4'h1: w[6:4] = 3'd5;
                    4'h6, 4'h7: w[6:4] = 3'd1;
                    4'h8, 4'h9: w[6:4] = 3'd2;
                    4'hA, 4'hB: w[6:4] = 3'd3;
                    default: w[6:4] = 3'd0;
                endcase
            end
            3: if (o == 4'h2) begin w[11] = 1; w[13] = 1; w[10] = 1; w[1] = 1; end
               else if (o == 4'h3) begin w[11] = 1; w[12] = 1; end
               else if (known) w[1] = 1;
            4: w[0] = known && (o != 4'h3);
            default: ;
        endcase
        return w;
    endfunction

    function automatic string tag(int ph, logic [3:0] o);
        if (ph == 0) return "R3";
        if (ph == 1) return "R4";
        if (o == 4'hC) return "R11";
        if (o > 4'hC) return "R12";
        if (ph == 2) return (o == 4'h3) ? "R8" : "R5";
        if (ph == 3) return (o == 4'h2) ? "R7" : (o == 4'h3) ? "R8" : "R9";
        return "R10";
    endfunction

    // Scenario: reset returns to fetch with halt cleared.
    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        #1;
        chk("R1 phase", phase, 0);
        chk("R1 halted", halted, 0);
        chk("R1 word", word, exp_word(0, 4'h0));
    endtask

    // Scenario: one instruction through all five phases.
    task automatic t_instr(logic [3:0] o);
        for (int ph = 0; ph < 5; ph++) begin
            opcode = (ph == 0) ? ~o : o;
            #1;
            chk("R2 phase", phase, ph);
            chk(tag(ph, o), word, exp_word(ph, o));
            if (ph == 2) begin
                chk("R5 alu_op", alu_op, exp_word(2, o) >> 4 & 3'h7);
                chk("R6 opb_imm", opb_imm, exp_word(2, o) >> 7 & 1'b1);
            end
            if (ph == 4) chk("R10 reg_wr", reg_wr, exp_word(4, o) & 1'b1);
            if (ph >= 2 && o == 4'hC) chk("R11 halted", halted, 1);
            step();
        end
    endtask

    // Scenario: every opcode back to back, including the no-op codes.
    task automatic t_all_ops();
        for (int o = 0; o < 16; o++) begin
            if (o != 12) t_instr(4'(o));
        end
        chk("R12 not halted", halted, 0);
    endtask

    // Scenario: halt parks at fetch and ignores the opcode until reset.
    task automatic t_halt();
        t_instr(4'h2);
        t_instr(4'hC);
        for (int i = 0; i < 8; i++) begin
            opcode = 4'(i * 3 + 1);
            #1;
            chk("R11 parked phase", phase, 0);
            chk("R11 parked word", word, 16'h0);
            chk("R11 halted", halted, 1);
            step();
        end
        t_reset();
        t_instr(4'h4);
    endtask

    // Scenario: reset in the middle of an instruction.
    task automatic t_mid_reset();
        opcode = 4'h3;
        step();
        step();
        #1;
        chk("R2 exec reached", phase, 2);
        t_reset();
        t_instr(4'h1);
    endtask

    initial begin
        t_reset();
        t_all_ops();
        t_halt();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule